// File: doc/BRIEF.md
# Coprocessor Interrupt Control Unit

This block is the interrupt side of a small coprocessor for a simple 32-bit pipelined CPU. It keeps a status word made of an 8-bit interrupt mask and a three-deep enable stack (current, previous, old). It also keeps an exception return PC. In every cycle it looks at eight level-sensitive request lines and decides whether fetch must be sent to a fixed handler address. When it takes an interrupt, it saves the PC that would otherwise have been fetched and pushes the enable stack. A restore-from-exception command pops the stack.

The CPU feeds in the word address it is about to fetch (an incremented PC or a taken-jump target), a flag that the instruction now in decode is a branch or jump, a status-write strobe with its data word, and a restore strobe. The block returns a redirect enable with the handler word address, plus a read port that reports status, pending requests or the saved PC. Interrupts are held off while a branch sits in decode and for one cycle after that, so that a delay-slot instruction is never the return point.

Top module: `cp0_intr_ctrl`

## Requirements
- R1: `take_irq` is 1 exactly when the AND of the mask and `irq_req` is nonzero, the current-enable bit is 1, `br_in_decode` is 0 and no branch was in decode in the last non-held cycle. It is combinational on the current state and inputs.
- R2: While `br_in_decode` is 1, and in the cycle after a non-held cycle with `br_in_decode` at 1, `take_irq` stays 0.
- R3: When an interrupt is taken in a non-held cycle, the enable stack is pushed at the clock edge: old gets previous, previous gets current, current becomes 0.
- R4: When an interrupt is taken in a non-held cycle, the saved PC gets `next_pc`. Reading select 2 returns the saved word address shifted left by 2.
- R5: When `take_irq` is 1, `redirect_pc` is the handler byte address 0x200000C0 as a word address (0x08000030).
- R6: A restore pulse pops the stack: current gets previous, previous gets old, and old is unchanged. The pop is applied before a push in the same cycle, so restore plus interrupt leaves current 0, previous at its old value and old unchanged.
- R7: A status write loads the mask from data bits 15:8, current from bit 0, previous from bit 2 and old from bit 4. It overrides a restore in the same cycle and is applied before a push. Reading select 0 returns the status in those same positions, with zeros elsewhere.
- R8: Reading select 1 returns `irq_req` in bits 15:8 and zeros elsewhere. Select 3 returns zero.
- R9: While `hold` is 1, the mask, the enable stack, the saved PC and the branch history do not change.
- R10: A clock edge with `rst_n` low clears the mask, all enable bits, the saved PC and the branch history, even while `hold` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | Freezes all state |
| irq_req | input | 8 | Interrupt request lines |
| next_pc | input | 30 | Word address that would be fetched next |
| br_in_decode | input | 1 | Instruction in decode is a branch or jump |
| wr_status | input | 1 | Status register write strobe |
| wr_data | input | 32 | Status write data |
| restore | input | 1 | Restore-from-exception strobe |
| rd_sel | input | 2 | Read select: 0 status, 1 requests, 2 saved PC, 3 zero |
| take_irq | output | 1 | Redirect fetch to the handler |
| redirect_pc | output | 30 | Handler word address |
| rd_data | output | 32 | Read data |

## Verification
The redirect decision and the read port are combinational. The bench samples them one time unit after it drives inputs on the falling edge, with no clock edge in between. Stack, mask and saved-PC updates appear after exactly one rising edge, so they are read back at the next falling edge. Branch blocking lasts two cycles, so it is checked at that cycle and the next one, and a taken interrupt is expected on the third. The gate sweep runs with `hold` high, which keeps the state fixed while every request pattern is presented.

// File: rtl/cp0_intr_pkg.sv
// Package: shared status type, read-select codes and stack helpers.
// Assumes an 8-bit mask that sits at bits 15:8 of the 32-bit data word.
package cp0_intr_pkg;
    parameter int IRQ_W     = 8;
    parameter int DATA_W    = 32;
    localparam int PC_W     = DATA_W - 2;
    localparam int MASK_LSB = 8;
    localparam int CUR_BIT  = 0;
    localparam int PREV_BIT = 2;
    localparam int OLD_BIT  = 4;

    typedef struct packed {
        logic [IRQ_W-1:0] mask;
        logic             ie_old;
        logic             ie_prev;
        logic             ie_cur;
    } cp0_status_t;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_ZERO   = 2'd3
    } rd_sel_e;

    // Push: shift enables toward old, clear current.
    function automatic cp0_status_t stack_push(cp0_status_t s);
        cp0_status_t r = s;
        r.ie_old  = s.ie_prev;
        r.ie_prev = s.ie_cur;
        r.ie_cur  = 1'b0;
        return r;
    endfunction

    // Pop: shift enables toward current, old keeps its value.
    function automatic cp0_status_t stack_pop(cp0_status_t s);
        cp0_status_t r = s;
        r.ie_cur  = s.ie_prev;
        r.ie_prev = s.ie_old;
        return r;
    endfunction

    // Unpack a data word into status fields.
    function automatic cp0_status_t status_from_word(logic [DATA_W-1:0] w);
        cp0_status_t r;
        r.mask    = w[MASK_LSB +: IRQ_W];
        r.ie_old  = w[OLD_BIT];
        r.ie_prev = w[PREV_BIT];
        r.ie_cur  = w[CUR_BIT];
        return r;
    endfunction

    // Pack status fields into a data word.
    function automatic logic [DATA_W-1:0] status_to_word(cp0_status_t s);
        logic [DATA_W-1:0] w = '0;
        w[MASK_LSB +: IRQ_W] = s.mask;
        w[OLD_BIT]           = s.ie_old;
        w[PREV_BIT]          = s.ie_prev;
        w[CUR_BIT]           = s.ie_cur;
        return w;
    endfunction
endpackage

// File: rtl/cp0_irq_gate.sv
// Decides whether an interrupt is taken this cycle.
// Assumes: mask and enable come from registered state; the branch flag
// refers to the instruction currently in decode.
module cp0_irq_gate #(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [IRQ_W-1:0] irq_req,
    input  logic [IRQ_W-1:0] mask,
    input  logic             ie_cur,
    input  logic             br_now,
    output logic             take
);
    logic br_last;

    // Remember a branch in decode for one more non-held cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            br_last <= 1'b0;
        else if (!hold)
            br_last <= br_now;
    end

    // Combine the masked requests, the enable and both delay-slot blocks.
    always_comb begin
        take = (|(mask & irq_req)) && ie_cur && !br_now && !br_last;
    end
endmodule

// File: rtl/cp0_status_reg.sv
// Status register: mask plus three-level enable stack.
// Assumes: restore is applied first, then a write, then a push.
module cp0_status_reg
    import cp0_intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              restore,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              take,
    output cp0_status_t       status_q
);
    cp0_status_t status_d;

    // Apply the update order: pop, write, push.
    always_comb begin
        status_d = status_q;
        if (restore) status_d = stack_pop(status_d);
        if (wr_en)   status_d = status_from_word(wr_word);
        if (take)    status_d = stack_push(status_d);
    end

    // Store status; reset wins over hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (!hold)
            status_q <= status_d;
    end
endmodule

// File: rtl/cp0_epc_reg.sv
// Exception return PC register, loaded when an interrupt is taken.
// Assumes next_pc is already the final next fetch word address.
module cp0_epc_reg #(
    parameter int PC_W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            take,
    input  logic [PC_W-1:0] next_pc,
    output logic [PC_W-1:0] epc_q
);
    // Capture the return address on a taken interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            epc_q <= '0;
        else if (!hold && take)
            epc_q <= next_pc;
    end
endmodule

// File: rtl/cp0_read_mux.sv
// Read port: status, raw requests or saved PC, chosen by select.
// Assumes the select encoding of rd_sel_e.
module cp0_read_mux
    import cp0_intr_pkg::*;
(
    input  cp0_status_t       status_q,
    input  logic [IRQ_W-1:0]  irq_req,
    input  logic [PC_W-1:0]   epc_q,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] data
);
    // Pick and format the selected source.
    always_comb begin
        data = '0;
        case (rd_sel_e'(sel))
            SEL_STATUS: data = status_to_word(status_q);
            SEL_CAUSE:  data[MASK_LSB +: IRQ_W] = irq_req;
            SEL_EPC:    data = {epc_q, 2'b00};
            default:    data = '0;
        endcase
    end
endmodule

// File: rtl/cp0_intr_ctrl.sv
// Top: coprocessor interrupt control unit.
// Assumes one instruction per non-held cycle and that the CPU uses
// redirect_pc whenever take_irq is high.
module cp0_intr_ctrl
    import cp0_intr_pkg::*;
#(
    parameter logic [31:0] HANDLER_ADDR = 32'h2000_00C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [IRQ_W-1:0]  irq_req,
    input  logic [PC_W-1:0]   next_pc,
    input  logic              br_in_decode,
    input  logic              wr_status,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              restore,
    input  logic [1:0]        rd_sel,
    output logic              take_irq,
    output logic [PC_W-1:0]   redirect_pc,
    output logic [DATA_W-1:0] rd_data
);
    cp0_status_t     status_q;
    logic [PC_W-1:0] epc_q;

    cp0_irq_gate #(.IRQ_W(IRQ_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .irq_req (irq_req),
        .mask    (status_q.mask),
        .ie_cur  (status_q.ie_cur),
        .br_now  (br_in_decode),
        .take    (take_irq)
    );

    cp0_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .restore  (restore),
        .wr_en    (wr_status),
        .wr_word  (wr_data),
        .take     (take_irq),
        .status_q (status_q)
    );

    cp0_epc_reg #(.PC_W(PC_W)) u_epc (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .take    (take_irq),
        .next_pc (next_pc),
        .epc_q   (epc_q)
    );

    cp0_read_mux u_rd (
        .status_q (status_q),
        .irq_req  (irq_req),
        .epc_q    (epc_q),
        .sel      (rd_sel),
        .data     (rd_data)
    );

    // Handler word address driven on every cycle.
    always_comb begin
        redirect_pc = HANDLER_ADDR[DATA_W-1:2];
    end
endmodule

// File: rtl/cp0_intr_ctrl_chk.sv
// Checker for cp0_intr_ctrl, attached by bind below.
module cp0_intr_ctrl_chk
    import cp0_intr_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            hold,
    input logic [IRQ_W-1:0] irq_req,
    input logic            br_in_decode,
    input logic            wr_status,
    input logic            restore,
    input logic [PC_W-1:0] next_pc,
    input logic            take_irq,
    input cp0_status_t     status_q,
    input logic [PC_W-1:0] epc_q
);
    p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ((|(status_q.mask & irq_req)) && status_q.ie_cur));

    p_branch_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
        br_in_decode |-> !take_irq);

    p_branch_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_in_decode && !hold) |=> !take_irq);

    p_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !hold && !restore && !wr_status) |=>
        (!status_q.ie_cur && status_q.ie_prev == $past(status_q.ie_cur)
         && status_q.ie_old == $past(status_q.ie_prev)));

    p_epc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !hold) |=> (epc_q == $past(next_pc)));

    p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !wr_status && !take_irq && !hold) |=>
        (status_q.ie_cur == $past(status_q.ie_prev)
         && status_q.ie_prev == $past(status_q.ie_old)
         && status_q.ie_old == $past(status_q.ie_old)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(status_q) && $stable(epc_q)));

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && epc_q == '0));
endmodule

bind cp0_intr_ctrl cp0_intr_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold         (hold),
    .irq_req      (irq_req),
    .br_in_decode (br_in_decode),
    .wr_status    (wr_status),
    .restore      (restore),
    .next_pc      (next_pc),
    .take_irq     (take_irq),
    .status_q     (status_q),
    .epc_q        (epc_q)
);

// File: tb/cp0_intr_ctrl_test.sv
module cp0_intr_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0;
    logic [7:0]  irq_req = '0;
    logic [29:0] next_pc = '0;
    logic        br_in_decode = 1'b0;
    logic        wr_status = 1'b0;
    logic [31:0] wr_data = '0;
    logic        restore = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic        take_irq;
    logic [29:0] redirect_pc;
    logic [31:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cp0_intr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .irq_req(irq_req),
        .next_pc(next_pc), .br_in_decode(br_in_decode), .wr_status(wr_status),
        .wr_data(wr_data), .restore(restore), .rd_sel(rd_sel),
        .take_irq(take_irq), .redirect_pc(redirect_pc), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_chk(input logic [1:0] sel, input logic [31:0] exp,
                            input string tag);
        rd_sel = sel;
        #1;
        check(rd_data === exp, tag, rd_data, exp);
    endtask

    task automatic write_st(input logic [31:0] v);
        wr_status = 1'b1; wr_data = v; irq_req = '0; hold = 1'b0;
        restore = 1'b0; br_in_decode = 1'b0;
        cyc();
        wr_status = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10: reset with hold high still clears
        rst_n = 1'b0; hold = 1'b1;
        cyc(); cyc();
        rst_n = 1'b1; hold = 1'b0;
        read_chk(2'd0, 32'h0, "R10 status after reset");
        read_chk(2'd2, 32'h0, "R10 epc after reset");
        check(take_irq === 1'b0, "R10 no take after reset", {31'b0, take_irq}, 0);

        // R7: write fields, other bits ignored on read-back
        write_st(32'hFFFF_FFFF);
        read_chk(2'd0, 32'h0000_FF15, "R7 status write all ones");
        write_st(32'h0000_A504);
        read_chk(2'd0, 32'h0000_A504, "R7 status write pattern");

        // R8: cause read and zero select
        hold = 1'b1; irq_req = 8'h5A;
        read_chk(2'd1, 32'h0000_5A00, "R8 cause read");
        read_chk(2'd3, 32'h0, "R8 select 3 zero");
        irq_req = '0; hold = 1'b0;

        // R1/R5: gate sweep with hold high
        for (int mi = 0; mi < 16; mi++) begin
            for (int c = 0; c < 2; c++) begin
                logic [7:0] m;
                m = 8'(mi * 17);
                write_st({16'b0, m, 7'b0, 1'(c)});
                hold = 1'b1;
                for (int i = 0; i < 256; i++) begin
                    bit exp;
                    irq_req = 8'(i);
                    #1;
                    exp = ((m & 8'(i)) != 0) && (c == 1);
                    check(take_irq === exp, "R1 gate", {31'b0, take_irq}, {31'b0, exp});
                    if (exp)
                        check(redirect_pc === 30'h0800_0030, "R5 handler",
                              {2'b0, redirect_pc}, 32'h0800_0030);
                    @(negedge clk);
                end
                irq_req = '0; hold = 1'b0;
            end
        end

        // R3/R4: take an interrupt
        write_st(32'h0000_0105);
        irq_req = 8'h01; next_pc = 30'h0123_4567;
        #1;
        check(take_irq === 1'b1, "R3 take", {31'b0, take_irq}, 1);
        cyc();
        irq_req = '0;
        read_chk(2'd0, 32'h0000_0114, "R3 push");
        read_chk(2'd2, 32'h048D_159C, "R4 epc");

        // R6: pops
        write_st(32'h0000_0110);
        restore = 1'b1; cyc(); restore = 1'b0;
        read_chk(2'd0, 32'h0000_0114, "R6 pop 1");
        restore = 1'b1; cyc(); restore = 1'b0;
        read_chk(2'd0, 32'h0000_0115, "R6 pop 2");

        // R6: pop and push in one cycle
        write_st(32'h0000_0111);
        restore = 1'b1; irq_req = 8'h01;
        cyc();
        restore = 1'b0; irq_req = '0;
        read_chk(2'd0, 32'h0000_0110, "R6 pop then push");

        // R7: write then push in one cycle
        write_st(32'h0000_0101);
        wr_status = 1'b1; wr_data = 32'h0000_0314; irq_req = 8'h01;
        cyc();
        wr_status = 1'b0; irq_req = '0;
        read_chk(2'd0, 32'h0000_0310, "R7 write then push");

        // R7: write overrides restore
        write_st(32'h0000_0104);
        wr_status = 1'b1; wr_data = 32'h0000_0110; restore = 1'b1;
        cyc();
        wr_status = 1'b0; restore = 1'b0;
        read_chk(2'd0, 32'h0000_0110, "R7 write over restore");

        // R2: branch blocks this cycle and the next
        write_st(32'h0000_0101);
        irq_req = 8'h01; br_in_decode = 1'b1; next_pc = 30'h0000_0ABC;
        #1;
        check(take_irq === 1'b0, "R2 blocked in branch", {31'b0, take_irq}, 0);
        cyc();
        br_in_decode = 1'b0;
        #1;
        check(take_irq === 1'b0, "R2 blocked after branch", {31'b0, take_irq}, 0);
        cyc();
        next_pc = 30'h2AAA_5555;
        #1;
        check(take_irq === 1'b1, "R2 taken after window", {31'b0, take_irq}, 1);
        cyc();
        irq_req = '0;
        read_chk(2'd2, 32'hAAA9_5554, "R4 epc jump target");

        // R9: hold freezes state
        write_st(32'h0000_0105);
        hold = 1'b1; irq_req = 8'h01; restore = 1'b1; wr_status = 1'b1;
        wr_data = 32'h0000_FF00; next_pc = 30'h0000_1111;
        cyc(); cyc();
        restore = 1'b0; wr_status = 1'b0; irq_req = '0;
        read_chk(2'd0, 32'h0000_0105, "R9 status held");
        read_chk(2'd2, 32'hAAA9_5554, "R9 epc held");
        hold = 1'b0;

        // R10: reset mid-run
        rst_n = 1'b0; hold = 1'b1;
        cyc();
        rst_n = 1'b1; hold = 1'b0;
        read_chk(2'd0, 32'h0, "R10 status mid reset");
        read_chk(2'd2, 32'h0, "R10 epc mid reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule